// File: doc/BRIEF.md
# Polled Serial Port Register Front End

This block sits between a simple single-cycle processor bus and the byte-level halves of a serial port. Software sees two locations. A data location at byte offset 0x10 gives the most recently received character when read and takes a character to send when written. A status location at byte offset 0x14 carries flags that a polling loop tests before it touches the data location. One byte is held in each direction, and there is no queueing.

On the line side, a receiver presents each finished character with a one-cycle strobe. A transmitter takes each character through a one-cycle start pulse and returns a one-cycle done pulse when the character has gone out. An interrupt output lets software wait for received data without polling, when it chooses to enable it.

Top module: `serial_mmio_regs`

## Requirements
- R1: After reset, receive-ready (status bit 0) is 0, transmit-ready (status bit 1) is 1, overrun (status bit 2) is 0, the interrupt enable (status bit 3) is 0, bus_rdata is 0, tx_start is 0 and rx_irq is 0.
- R2: A selected read (bus_sel=1, bus_we=0) presents its result on bus_rdata from the clock edge that ends the read cycle, and holds it until the next selected read. A read of offset 0x10 returns the held received byte in bits 7:0 with bits 31:8 zero. A read of offset 0x14 returns the four status bits in bits 3:0 with bits 31:4 zero.
- R3: An rx_strobe pulse stores rx_byte and sets receive-ready. A selected read of offset 0x10 clears receive-ready.
- R4: An rx_strobe while receive-ready is 1 and no data read is in progress overwrites the held byte and sets the sticky overrun bit.
- R5: A selected read of offset 0x14 clears overrun after returning it. If a new overrun happens in the same cycle, overrun stays 1.
- R6: A selected write of offset 0x10 while transmit-ready is 1 clears transmit-ready and raises tx_start for exactly one cycle after that edge, with bus_wdata bits 7:0 on tx_byte.
- R7: A selected write of offset 0x10 while transmit-ready is 0 is dropped. No tx_start is raised and tx_byte keeps the character in flight.
- R8: A tx_done pulse while transmit-ready is 0 sets transmit-ready again.
- R9: A selected write of offset 0x14 loads status bit 3 (interrupt enable) from bus_wdata bit 3 and leaves bits 0 to 2 unchanged. rx_irq is 1 exactly when receive-ready and the enable are both 1.
- R10: Cycles with bus_sel=0 have no side effect on any flag, byte or output. A selected read of any offset other than 0x10 and 0x14 returns 0.
- R11: When rx_strobe coincides with a selected read of offset 0x10, the read returns the old byte. The new byte is then held with receive-ready 1, and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus cycle targets this block |
| bus_we | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | input | 5 | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_strobe | input | 1 | One-cycle pulse: rx_byte holds a new character |
| rx_byte | input | 8 | Character from the line receiver |
| tx_start | output | 1 | One-cycle pulse: send tx_byte |
| tx_byte | output | 8 | Character handed to the line transmitter |
| tx_done | input | 1 | One-cycle pulse: previous character has gone out |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
All 256 character values are passed through both directions and every offset is read. A datapath that narrowed or failed to zero-extend a value would show up as a wrong byte or as stray upper bits. The bench stacks events on the same cycle: a strobe landing on a data read, which a careless design would flag as overrun or would use to lose the new byte, and an overrun landing on a status read, which a design that lets the clear win would hide. It also writes to the data location while the transmitter is busy, which a design without the guard would turn into a second start pulse and a corrupted byte in flight. Unselected cycles that carry read and write patterns check that side effects stay tied to bus_sel.

// File: rtl/serport_pkg.sv
package serport_pkg;
  localparam int BUS_W  = 32;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_DATA = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h14;

  // status bit positions (software decodes these)
  localparam int ST_RXRDY = 0;
  localparam int ST_TXRDY = 1;
  localparam int ST_OVR   = 2;
  localparam int ST_IEN   = 3;
  localparam int ST_W     = 4;

  function automatic logic [BUS_W-1:0] zext_byte(input logic [DATA_W-1:0] b);
    logic [BUS_W-1:0] r;
    r = '0;
    r[DATA_W-1:0] = b;
    return r;
  endfunction

  function automatic logic [BUS_W-1:0] pack_status(input logic rx_rdy,
                                                    input logic tx_rdy,
                                                    input logic ovr,
                                                    input logic ien);
    logic [BUS_W-1:0] r;
    r = '0;
    r[ST_RXRDY] = rx_rdy;
    r[ST_TXRDY] = tx_rdy;
    r[ST_OVR]   = ovr;
    r[ST_IEN]   = ien;
    return r;
  endfunction
endpackage

// File: rtl/serport_decode.sv
module serport_decode
  import serport_pkg::*;
(
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_any,
  output logic              rd_data,
  output logic              rd_stat,
  output logic              wr_data,
  output logic              wr_stat
);
  logic hit_data, hit_stat;

  always_comb begin
    hit_data = (addr == OFS_DATA);
    hit_stat = (addr == OFS_STAT);
    rd_any   = sel && !we;
    rd_data  = rd_any && hit_data;
    rd_stat  = rd_any && hit_stat;
    wr_data  = sel && we && hit_data;
    wr_stat  = sel && we && hit_stat;
  end
endmodule

// File: rtl/serport_rx_hold.sv
module serport_rx_hold
  import serport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              consume,
  input  logic              clr_ovr,
  output logic [DATA_W-1:0] held,
  output logic              full,
  output logic              ovr,
  output logic              overrun_ev
);
  assign overrun_ev = strobe && full && !consume;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      full <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (strobe) held <= byte_in;

      if (strobe)       full <= 1'b1;
      else if (consume) full <= 1'b0;

      if (overrun_ev)   ovr <= 1'b1;
      else if (clr_ovr) ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/serport_tx_hold.sv
module serport_tx_hold
  import serport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              done,
  output logic              free,
  output logic              start,
  output logic [DATA_W-1:0] byte_out,
  output logic              accept_ev,
  output logic              drop_ev
);
  assign accept_ev = load && free;
  assign drop_ev   = load && !free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free     <= 1'b1;
      start    <= 1'b0;
      byte_out <= '0;
    end else begin
      start <= accept_ev;
      if (accept_ev) begin
        free     <= 1'b0;
        byte_out <= byte_in;
      end else if (done && !free) begin
        free <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_mmio_regs.sv
module serial_mmio_regs
  import serport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              rx_strobe,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              tx_start,
  output logic [DATA_W-1:0] tx_byte,
  input  logic              tx_done,
  output logic              rx_irq
);
  // internal events and state, named for the checker
  logic              rd_any, rd_data_ev, rd_stat_ev, wr_data_ev, wr_stat_ev;
  logic [DATA_W-1:0] rx_held;
  logic              rx_full, ovr_flag, overrun_ev;
  logic              tx_free, tx_accept_ev, tx_drop_ev;
  logic              irq_en;
  logic [BUS_W-1:0]  rd_next;
  logic              unused_wr_bits;

  assign unused_wr_bits = ^{bus_wdata[BUS_W-1:ST_IEN+1], bus_wdata[ST_IEN-1:0]};

  serport_decode u_dec (
    .sel     (bus_sel),
    .we      (bus_we),
    .addr    (bus_addr),
    .rd_any  (rd_any),
    .rd_data (rd_data_ev),
    .rd_stat (rd_stat_ev),
    .wr_data (wr_data_ev),
    .wr_stat (wr_stat_ev)
  );

  serport_rx_hold u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (rx_strobe),
    .byte_in    (rx_byte),
    .consume    (rd_data_ev),
    .clr_ovr    (rd_stat_ev),
    .held       (rx_held),
    .full       (rx_full),
    .ovr        (ovr_flag),
    .overrun_ev (overrun_ev)
  );

  serport_tx_hold u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_data_ev),
    .byte_in   (bus_wdata[DATA_W-1:0]),
    .done      (tx_done),
    .free      (tx_free),
    .start     (tx_start),
    .byte_out  (tx_byte),
    .accept_ev (tx_accept_ev),
    .drop_ev   (tx_drop_ev)
  );

  always_comb begin
    if (rd_data_ev)      rd_next = zext_byte(rx_held);
    else if (rd_stat_ev) rd_next = pack_status(rx_full, tx_free, ovr_flag, irq_en);
    else                 rd_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      irq_en    <= 1'b0;
    end else begin
      if (rd_any)     bus_rdata <= rd_next;
      if (wr_stat_ev) irq_en    <= bus_wdata[ST_IEN];
    end
  end

  assign rx_irq = rx_full && irq_en;
endmodule

// File: rtl/serial_mmio_regs_chk.sv
module serial_mmio_regs_chk
  import serport_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              rx_strobe,
  input logic              tx_done,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              tx_start,
  input logic [DATA_W-1:0] tx_byte,
  input logic              rx_irq,
  input logic              rd_data_ev,
  input logic              rd_stat_ev,
  input logic              wr_data_ev,
  input logic              rx_full,
  input logic              tx_free,
  input logic              ovr_flag,
  input logic              overrun_ev,
  input logic              irq_en
);
  assert_zero_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_ev |=> bus_rdata[BUS_W-1:DATA_W] == '0);

  assert_stat_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat_ev |=> bus_rdata[BUS_W-1:ST_W] == '0);

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_ev && !rx_strobe) |=> !rx_full);

  assert_strobe_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |=> rx_full);

  assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_ev |=> ovr_flag);

  assert_ovr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_ev && !overrun_ev) |=> !ovr_flag);

  assert_start_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_ev && tx_free) |=> (tx_start && !tx_free && tx_byte == $past(bus_wdata[DATA_W-1:0])));

  assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  assert_drop_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_ev && !tx_free) |=> (!tx_start && $stable(tx_byte)));

  assert_done_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tx_free) |=> tx_free);

  assert_irq_needs_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (rx_full && irq_en));

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel && !rx_strobe && !tx_done) |=>
      ($stable(rx_full) && $stable(tx_free) && $stable(ovr_flag) && $stable(irq_en) && $stable(bus_rdata)));

  assert_coincide_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_ev && rx_strobe) |=> (rx_full && $stable(ovr_flag)));
endmodule

bind serial_mmio_regs serial_mmio_regs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .rx_strobe  (rx_strobe),
  .tx_done    (tx_done),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .tx_start   (tx_start),
  .tx_byte    (tx_byte),
  .rx_irq     (rx_irq),
  .rd_data_ev (rd_data_ev),
  .rd_stat_ev (rd_stat_ev),
  .wr_data_ev (wr_data_ev),
  .rx_full    (rx_full),
  .tx_free    (tx_free),
  .ovr_flag   (ovr_flag),
  .overrun_ev (overrun_ev),
  .irq_en     (irq_en)
);

// File: tb/serial_mmio_regs_tb.sv
module serial_mmio_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_strobe = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_start;
  logic [7:0]  tx_byte;
  logic        tx_done = 1'b0;
  logic        rx_irq;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  serial_mmio_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_strobe(rx_strobe), .rx_byte(rx_byte), .tx_start(tx_start),
    .tx_byte(tx_byte), .tx_done(tx_done), .rx_irq(rx_irq)
  );

  function automatic logic [31:0] st(input bit rx, input bit tx, input bit ov, input bit ie);
    return 32'(rx) + 32'(tx) * 2 + 32'(ov) * 4 + 32'(ie) * 8;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle; extra line-side strobes may ride on it
  task automatic cyc(input bit sel, input bit we, input logic [4:0] a, input logic [31:0] d,
                     input bit strb, input logic [7:0] b, input bit done);
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d;
    rx_strobe = strb; rx_byte = b; tx_done = done;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0; rx_strobe = 0; tx_done = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    cyc(1, 0, a, 32'hFFFF_FFFF, 0, 8'h00, 0);
    v = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    #9 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 tx_start", {31'h0, tx_start}, 32'h0);
    chk("R1 irq", {31'h0, rx_irq}, 32'h0);
    rd(5'h14, v); chk("R1 status", v, st(0, 1, 0, 0));

    // R2 R3: every receive value through the data location
    for (int b = 0; b < 256; b++) begin
      cyc(0, 0, 5'h0, 0, 1, 8'(b), 0);
      rd(5'h14, v); chk("R3 rx ready set", v, st(1, 1, 0, 0));
      rd(5'h10, v); chk("R2 data zero-ext", v, 32'(b));
      rd(5'h14, v); chk("R3 rx ready cleared", v, st(0, 1, 0, 0));
    end

    // R6 R8: every transmit value
    for (int b = 0; b < 256; b++) begin
      cyc(1, 1, 5'h10, {24'hA5A5A5, 8'(b)}, 0, 8'h00, 0);
      chk("R6 start pulse", {31'h0, tx_start}, 32'h1);
      chk("R6 byte", {24'h0, tx_byte}, 32'(b));
      rd(5'h14, v); chk("R6 tx busy", v, st(0, 0, 0, 0));
      chk("R6 single pulse", {31'h0, tx_start}, 32'h0);
      cyc(0, 0, 5'h0, 0, 0, 8'h00, 1);
      rd(5'h14, v); chk("R8 tx ready again", v, st(0, 1, 0, 0));
    end

    // R7 write while busy dropped
    cyc(1, 1, 5'h10, 32'h3C, 0, 8'h00, 0);
    cyc(1, 1, 5'h10, 32'hC3, 0, 8'h00, 0);
    chk("R7 no start", {31'h0, tx_start}, 32'h0);
    chk("R7 byte kept", {24'h0, tx_byte}, 32'h3C);
    cyc(1, 1, 5'h10, 32'h99, 0, 8'h00, 1); // done and write together: write dropped
    chk("R7 no start with done", {31'h0, tx_start}, 32'h0);
    chk("R7 byte kept with done", {24'h0, tx_byte}, 32'h3C);
    rd(5'h14, v); chk("R8 done frees", v, st(0, 1, 0, 0));

    // R4 R5 overrun
    cyc(0, 0, 5'h0, 0, 1, 8'h11, 0);
    cyc(0, 0, 5'h0, 0, 1, 8'h22, 0);
    rd(5'h14, v); chk("R4 overrun set", v, st(1, 1, 1, 0));
    rd(5'h14, v); chk("R5 overrun cleared", v, st(1, 1, 0, 0));
    rd(5'h10, v); chk("R4 newest byte", v, 32'h22);
    // R5 overrun coinciding with status read
    cyc(0, 0, 5'h0, 0, 1, 8'h33, 0);
    cyc(1, 0, 5'h14, 0, 1, 8'h44, 0);
    chk("R5 pre-edge status", bus_rdata, st(1, 1, 0, 0));
    rd(5'h14, v); chk("R5 set wins", v, st(1, 1, 1, 0));
    rd(5'h10, v); chk("R5 data", v, 32'h44);

    // R11 strobe on data read
    cyc(0, 0, 5'h0, 0, 1, 8'h55, 0);
    cyc(1, 0, 5'h10, 0, 1, 8'h66, 0);
    chk("R11 old byte", bus_rdata, 32'h55);
    rd(5'h14, v); chk("R11 ready no overrun", v, st(1, 1, 0, 0));
    rd(5'h10, v); chk("R11 new byte", v, 32'h66);

    // R9 interrupt enable and gating
    cyc(1, 1, 5'h14, 32'hFFFF_FFF7, 0, 8'h00, 0);
    rd(5'h14, v); chk("R9 bits 0-2 unchanged, enable 0", v, st(0, 1, 0, 0));
    cyc(1, 1, 5'h14, 32'h0000_0008, 0, 8'h00, 0);
    rd(5'h14, v); chk("R9 enable set", v, st(0, 1, 0, 1));
    chk("R9 irq off empty", {31'h0, rx_irq}, 32'h0);
    cyc(0, 0, 5'h0, 0, 1, 8'h77, 0);
    chk("R9 irq on", {31'h0, rx_irq}, 32'h1);
    cyc(1, 1, 5'h14, 32'h0, 0, 8'h00, 0);
    chk("R9 irq masked", {31'h0, rx_irq}, 32'h0);
    cyc(1, 1, 5'h14, 32'h8, 0, 8'h00, 0);
    chk("R9 irq unmasked", {31'h0, rx_irq}, 32'h1);
    rd(5'h10, v);
    chk("R9 irq cleared by read", {31'h0, rx_irq}, 32'h0);

    // R10 unselected cycles and unmapped offsets
    cyc(0, 0, 5'h0, 0, 1, 8'h88, 0);
    rd(5'h14, v);
    cyc(0, 1, 5'h10, 32'hEE, 0, 8'h00, 0);
    chk("R10 no start unselected", {31'h0, tx_start}, 32'h0);
    chk("R10 rdata held", bus_rdata, st(1, 1, 0, 1));
    cyc(0, 0, 5'h10, 0, 0, 8'h00, 0);
    cyc(0, 1, 5'h14, 32'h0, 0, 8'h00, 0);
    rd(5'h14, v); chk("R10 flags untouched", v, st(1, 1, 0, 1));
    for (int a = 0; a < 32; a++) begin
      if (a != 16 && a != 20) begin
        rd(5'(a), v); chk("R10 unmapped read", v, 32'h0);
      end
    end
    rd(5'h10, v); chk("R10 data survived", v, 32'h88);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule